// File: doc/BRIEF.md
# 8-bit ALU with Class-Dependent Flags

This block is the combinational arithmetic and logic stage of a small 8-bit processor. It accepts the current instruction byte, the selected accumulator value and the value of a second register operand. It returns an 8-bit result, a 2-bit flag value and an enable that tells the flag register whether to load that value. Register storage, fetch and sequencing are all outside the block. The caller writes the result back into the accumulator whenever the flag enable is high.

The two flag bits carry different meanings for different groups of operations. For additions and subtractions they hold signed overflow and carry or borrow. For AND, OR and XOR they hold a zero indicator and the parity of the result. For the two logical shifts they hold a zero indicator and the sign bit. The decoder uses only the upper bits of the instruction byte, plus the immediate field of the add-immediate form. The accumulator-select bit, bit 3, is left to the caller.

Top module: `alu8_core`

## Requirements
- R1: Opcode nibble 0010 (add) gives result = (acc_in + opnd_in) mod 256. Flag bit 1 is the carry out of bit 7. Flag bit 0 is signed overflow: both operands have the same bit 7 and the result's bit 7 differs from it.
- R2: Bytes whose bits 7:5 are 000 (add immediate) add a 4-bit immediate to acc_in. The immediate is formed as {instr[4], instr[2:0]} and zero-extended. The flags follow the R1 rule, with the immediate as the second operand.
- R3: Opcode nibble 0011 (subtract) gives result = (acc_in - opnd_in) mod 256. Flag bit 1 is the borrow, which is 1 when opnd_in > acc_in as unsigned values. Flag bit 0 is signed overflow: the operands' bit 7 values differ and the result's bit 7 differs from acc_in's.
- R4: Opcode nibbles 0111, 1100 and 1101 give the bitwise XOR, AND and OR of acc_in and opnd_in. Flag bit 0 is 1 when the result is zero. Flag bit 1 is the XOR of all result bits.
- R5: Opcode nibbles 1110 and 1111 shift acc_in logically left or right by opnd_in places. Any shift amount of 8 or more gives 0.
- R6: For the two shifts, flag bit 0 is 1 when the result is zero, and flag bit 1 equals result bit 7.
- R7: flag_we is 1 only for the opcodes listed in R1 to R6. For every other byte, flag_we is 0, flag_out is 00 and result equals acc_in.
- R8: Instruction bit 3 has no effect on result, flag_out or flag_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 8 | Current instruction byte |
| acc_in | input | 8 | Selected accumulator value |
| opnd_in | input | 8 | Second register operand (also the shift amount) |
| result | output | 8 | Value to write back to the accumulator |
| flag_out | output | 2 | New flag value, meaning set by operation class |
| flag_we | output | 1 | Flag and result update enable |

## Verification
The embedded assertions check relations that must hold for every input. Unlisted opcodes must pass the accumulator through with cleared flags. A shift result must agree with the sign flag. A logic-class zero flag must match the result. An add-immediate must never move the accumulator by 16 or more. A carry or borrow left clear must agree with the direction of the result. These checks cannot confirm exact sums, overflow on its own, parity, or the immediate bit assembly. The bench's sweep shows those by running every instruction byte against a set of boundary operands, including the signed limits 0x7F/0x80 and shift amounts around 8, and comparing against arithmetic computed in the bench.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_ADDI,
    OP_SUB,
    OP_XOR,
    OP_AND,
    OP_OR,
    OP_SLL,
    OP_SRL
  } alu_op_e;

  typedef enum logic [1:0] {
    FC_NONE,
    FC_ARITH,
    FC_LOGIC,
    FC_SHIFT
  } flag_class_e;

  localparam int INSTR_W = 8;
  localparam int IMM_W   = 4;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output alu_op_e            op,
  output flag_class_e        fclass,
  output logic [IMM_W-1:0]   imm
);

  logic unused_sel;
  assign unused_sel = instr[3];

  // immediate: bit 4 is the top bit, bits 2:0 the rest
  assign imm = {instr[4], instr[2:0]};

  always_comb begin
    casez (instr[7:4])
      4'b000?: op = OP_ADDI;
      4'b0010: op = OP_ADD;
      4'b0011: op = OP_SUB;
      4'b0111: op = OP_XOR;
      4'b1100: op = OP_AND;
      4'b1101: op = OP_OR;
      4'b1110: op = OP_SLL;
      4'b1111: op = OP_SRL;
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDI, OP_SUB: fclass = FC_ARITH;
      OP_XOR, OP_AND, OP_OR:   fclass = FC_LOGIC;
      OP_SLL, OP_SRL:          fclass = FC_SHIFT;
      default:                 fclass = FC_NONE;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     acc,
  input  logic [W-1:0]     opnd,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     res,
  output logic             carry,
  output logic             ovf
);

  localparam int SHW = $clog2(W);

  // shared adder input
  logic [W-1:0] addend;
  logic [W:0]   sum;
  logic [W:0]   diff;

  assign addend = (op == OP_ADDI) ? W'(imm) : opnd;
  assign sum    = {1'b0, acc} + {1'b0, addend};
  assign diff   = {1'b0, acc} - {1'b0, opnd};

  // range guard for the shift amount
  logic shift_big;
  assign shift_big = (opnd >= W'(W));

  // logarithmic shifters, one stage per amount bit
  logic [W-1:0] lsh;
  logic [W-1:0] rsh;

  always_comb begin
    lsh = acc;
    rsh = acc;
    for (int i = 0; i < SHW; i++) begin
      if (opnd[i]) begin
        lsh = lsh << (1 << i);
        rsh = rsh >> (1 << i);
      end
    end
    if (shift_big) begin
      lsh = '0;
      rsh = '0;
    end
  end

  always_comb begin
    res   = acc;
    carry = 1'b0;
    ovf   = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDI: begin
        res   = sum[W-1:0];
        carry = sum[W];
        ovf   = (acc[W-1] == addend[W-1]) && (sum[W-1] != acc[W-1]);
      end
      OP_SUB: begin
        res   = diff[W-1:0];
        carry = diff[W];
        ovf   = (acc[W-1] != opnd[W-1]) && (diff[W-1] != acc[W-1]);
      end
      OP_XOR:  res = acc ^ opnd;
      OP_AND:  res = acc & opnd;
      OP_OR:   res = acc | opnd;
      OP_SLL:  res = lsh;
      OP_SRL:  res = rsh;
      default: res = acc;
    endcase
  end

  logic [W-1:0] imm_step;
  assign imm_step = res - acc;

  always_comb begin
    if ((op == OP_SLL || op == OP_SRL) && shift_big)
      assert_shift_range_R5: assert (res == '0)
        else $error("oversized shift left nonzero result");
    if (op == OP_ADDI)
      assert_imm_bound_R2: assert (imm_step < W'(16))
        else $error("add-immediate moved accumulator too far");
    if (op == OP_SUB && !carry)
      assert_sub_borrow_R3: assert (res <= acc)
        else $error("no borrow but difference above minuend");
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  flag_class_e  fclass,
  input  logic [W-1:0] res,
  input  logic         carry,
  input  logic         ovf,
  output logic [1:0]   flags,
  output logic         flag_we
);

  logic is_zero;
  logic parity;

  assign is_zero = (res == '0);
  assign parity  = ^res;

  always_comb begin
    unique case (fclass)
      FC_ARITH: flags = {carry, ovf};
      FC_LOGIC: flags = {parity, is_zero};
      FC_SHIFT: flags = {res[W-1], is_zero};
      default:  flags = 2'b00;
    endcase
  end

  assign flag_we = (fclass != FC_NONE);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [7:0]   instr,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  output logic [W-1:0] result,
  output logic [1:0]   flag_out,
  output logic         flag_we
);

  alu_op_e          op;
  flag_class_e      fclass;
  logic [IMM_W-1:0] imm;
  logic             carry;
  logic             ovf;

  alu8_decode u_decode (
    .instr  (instr),
    .op     (op),
    .fclass (fclass),
    .imm    (imm)
  );

  alu8_datapath #(.W(W)) u_datapath (
    .op    (op),
    .acc   (acc_in),
    .opnd  (opnd_in),
    .imm   (imm),
    .res   (result),
    .carry (carry),
    .ovf   (ovf)
  );

  alu8_flags #(.W(W)) u_flags (
    .fclass  (fclass),
    .res     (result),
    .carry   (carry),
    .ovf     (ovf),
    .flags   (flag_out),
    .flag_we (flag_we)
  );

  always_comb begin
    if (!flag_we)
      assert_idle_passthru_R7: assert (result == acc_in && flag_out == 2'b00)
        else $error("unlisted opcode altered outputs");
    if (instr[7:5] == 3'b111)
      assert_shift_sign_R6: assert (flag_out[1] == result[W-1])
        else $error("shift sign flag disagrees with result");
    if (instr[7:4] == 4'b0111 || instr[7:5] == 3'b110)
      assert_logic_zero_R4: assert (flag_out[0] == (result == '0))
        else $error("logic zero flag disagrees with result");
    if (instr[7:4] == 4'b0010 && !flag_out[1])
      assert_add_carry_R1: assert (result >= acc_in)
        else $error("no carry but sum wrapped");
  end

endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;

  logic       clk;
  logic [7:0] instr;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic [7:0] result;
  logic [1:0] flag_out;
  logic       flag_we;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  alu8_core uut (
    .instr    (instr),
    .acc_in   (acc_in),
    .opnd_in  (opnd_in),
    .result   (result),
    .flag_out (flag_out),
    .flag_we  (flag_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] corner [0:19];
  initial begin
    corner = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08, 8'h09, 8'h0F,
               8'h10, 8'h3F, 8'h40, 8'h55, 8'h7E, 8'h7F, 8'h80, 8'h81,
               8'hAA, 8'hC3, 8'hFE, 8'hFF};
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (instr %0h acc %0h opnd %0h)",
               req, act, exp, instr, acc_in, opnd_in);
    end
  endtask

  // expected outputs: {we, flags, result}, from the requirement text
  function automatic logic [10:0] model(input logic [7:0] ins, input logic [7:0] a,
                                        input logic [7:0] b);
    logic [8:0] s;
    logic [7:0] r;
    logic [1:0] f;
    logic       we;
    logic [3:0] im;
    we = 1'b1;
    f  = 2'b00;
    r  = a;
    im = {ins[4], ins[2:0]};
    if (ins[7:5] == 3'b000) begin
      s = {1'b0, a} + {5'b0, im};
      r = s[7:0];
      f = {s[8], (!a[7] && r[7])};
    end else begin
      case (ins[7:4])
        4'h2: begin
          s = {1'b0, a} + {1'b0, b};
          r = s[7:0];
          f = {s[8], (a[7] == b[7]) && (r[7] != a[7])};
        end
        4'h3: begin
          r = a - b;
          f = {(b > a), (a[7] != b[7]) && (r[7] != a[7])};
        end
        4'h7, 4'hC, 4'hD: begin
          r = (ins[7:4] == 4'h7) ? (a ^ b) : (ins[7:4] == 4'hC) ? (a & b) : (a | b);
          f = {^r, (r == 8'h00)};
        end
        4'hE, 4'hF: begin
          if (b >= 8) r = 8'h00;
          else r = (ins[7:4] == 4'hE) ? (a << b) : (a >> b);
          f = {r[7], (r == 8'h00)};
        end
        default: begin
          we = 1'b0;
          r  = a;
          f  = 2'b00;
        end
      endcase
    end
    return {we, f, r};
  endfunction

  function automatic string res_tag(input logic [7:0] ins);
    if (ins[7:5] == 3'b000) return "R2";
    case (ins[7:4])
      4'h2: return "R1";
      4'h3: return "R3";
      4'h7, 4'hC, 4'hD: return "R4";
      4'hE, 4'hF: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic string flag_tag(input logic [7:0] ins);
    if (ins[7:4] == 4'hE || ins[7:4] == 4'hF) return "R6";
    return res_tag(ins);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [10:0] exp;
    instr   = 8'h40;
    acc_in  = 8'h00;
    opnd_in = 8'h00;
    @(posedge clk);
    #1;
    // reset-like idle state: unlisted opcode with zero operands
    check("R7 idle we", {7'b0, flag_we}, 8'h00);
    check("R7 idle flags", {6'b0, flag_out}, 8'h00);
    check("R7 idle result", result, 8'h00);

    for (int ins = 0; ins < 256; ins++) begin
      for (int ia = 0; ia < 20; ia++) begin
        for (int ib = 0; ib < 20; ib++) begin
          @(negedge clk);
          instr   = ins[7:0];
          acc_in  = corner[ia];
          opnd_in = corner[ib];
          @(posedge clk);
          #1;
          exp = model(instr, acc_in, opnd_in);
          // R8: bit 3 is absent from the model, so set-bit bytes test that it is ignored
          check({res_tag(instr), instr[3] ? " R8" : "", " result"}, result, exp[7:0]);
          check({flag_tag(instr), instr[3] ? " R8" : "", " flags"},
                {6'b0, flag_out}, {6'b0, exp[9:8]});
          check({"R7", instr[3] ? " R8" : "", " flag_we"},
                {7'b0, flag_we}, {7'b0, exp[10]});
        end
      end
    end

    // targeted corners
    @(negedge clk);
    instr = 8'h15; acc_in = 8'hFA; opnd_in = 8'h00;  // imm = 1101 = 13
    @(posedge clk); #1;
    check("R2 imm assembly result", result, 8'h07);
    check("R2 imm assembly carry", {6'b0, flag_out}, 8'h02);

    @(negedge clk);
    instr = 8'hE0; acc_in = 8'hFF; opnd_in = 8'h07;
    @(posedge clk); #1;
    check("R5 shift by 7", result, 8'h80);
    check("R6 shift sign", {6'b0, flag_out}, 8'h02);

    @(negedge clk);
    instr = 8'hF8; acc_in = 8'hFF; opnd_in = 8'h08;
    @(posedge clk); #1;
    check("R5 shift by 8", result, 8'h00);
    check("R6 shift zero", {6'b0, flag_out}, 8'h01);

    @(negedge clk);
    instr = 8'h30; acc_in = 8'h80; opnd_in = 8'h01;
    @(posedge clk); #1;
    check("R3 sub overflow", result, 8'h7F);
    check("R3 sub flags", {6'b0, flag_out}, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule